// File: doc/BRIEF.md
# Edge Limiter Coverage Evaluator

The block works out a coverage value for every pixel of a 2D primitive. Six linear edge functions are evaluated across a rectangular bounding box, scanned in raster order. Each edge function, called a limiter here, is a signed fixed-point value with 16 fractional bits. A start value seeds it. It then grows by an x step for each pixel and by a y step for each new row. Each limiter value becomes an 8-bit coverage, either graded (clamped to [0,1]) or hard (inside/outside). The six coverages are merged through a fixed tree of min/max stages: limiters 1 and 2 form A, 3 and 4 form B, and 5 and 6 form D. A and B form C, and C and D form the final value.

Software loads the configuration through a simple write port. The address map is as follows. Address 0 is control: enables in bits [5:0], threshold modes in [11:6] and stage selects in [16:12]. Address 1 is size: width in [10:0] and height in [26:16]. For limiter i (0..5), address 2+3i is its start value, 2+3i+1 its x step and 2+3i+2 its y step. A start strobe begins the scan. The block then streams one pixel per cycle, with its coordinates and coverage.

Top module: `edge_cov_eval`

## Requirements
- R1: After reset, busy_o, done_o and pix_valid_o are low.
- R2: A start accepted while idle makes pix_valid_o high from the next cycle. Pixels follow one per cycle in raster order: x runs 0..width-1 within each row, and rows run 0..height-1.
- R3: At pixel (x,y), limiter i holds start + x*xstep + y*ystep, modulo 2^32. Limiter i uses write addresses 2+3i (start), 3+3i (x step) and 4+3i (y step).
- R4: In graded mode, a negative value gives coverage 0x00. A value of 0x10000 (1.0) or more gives 0xFF. Any other value gives bits [15:8].
- R5: In threshold mode (control bit 6+i), a non-negative value gives 0xFF and a negative value gives 0x00.
- R6: A limiter whose enable (control bit i) is 0 feeds 0xFF into its pair stage when that stage selects min, and 0x00 when it selects max.
- R7: Control bits 12..16 select the stages A(1,2), B(3,4), D(5,6), C(A,B) and final(C,D). A select of 0 takes the minimum and 1 takes the maximum. pix_cov_o is the final value.
- R8: A start with width 0 or height 0 emits no pixels and keeps busy_o low. It raises done_o in the next cycle.
- R9: busy_o is high for exactly the pixel cycles of a scan. done_o is a one-cycle pulse in the cycle after the last pixel.
- R10: A start strobe while a scan is running is ignored. The scan goes on unchanged, and no further scan follows it.
- R11: Control (address 0) and size (address 1) are written with the field positions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| start_i | input | 1 | Start scan strobe |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle scan completion pulse |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_x_o | output | 11 | Pixel x coordinate |
| pix_y_o | output | 11 | Pixel y coordinate |
| pix_cov_o | output | 8 | Pixel coverage |

## Verification
The checker watches the handshake and the scan order on every cycle:
- busy_o and done_o never overlap.
- Every fall of busy_o brings a single done pulse.
- Start strobes lead to a scan or a done pulse.
- Successive pixels step x by one, or wrap to x 0 on the next row.

Coverage values, which depend on the fixed-point limiter arithmetic, clamping, threshold mode, disabled-limiter substitution and the min/max tree, can only be shown by the bench. It compares each pixel against its own model under directed and random configurations, including zero-size boxes.

// File: rtl/edge_cov_pkg.sv
package edge_cov_pkg;
  localparam int NUM_LIM  = 6;
  localparam int NUM_STG  = 5;
  localparam int VAL_W    = 32;
  localparam int FRAC_W   = 16;
  localparam int COV_W    = 8;
  localparam int DIM_W    = 11;
  localparam int ADDR_W   = 5;
  localparam int REG_BASE = 2;

  typedef logic signed [VAL_W-1:0] lim_val_t;
  typedef logic [COV_W-1:0]        cov_t;

  function automatic cov_t clip_cov(lim_val_t v, logic thr);
    cov_t r;
    if (thr)                            r = v[VAL_W-1] ? '0 : '1;
    else if (v[VAL_W-1])                r = '0;
    else if (v >= lim_val_t'(1 << FRAC_W)) r = '1;
    else                                r = v[FRAC_W-1 -: COV_W];
    return r;
  endfunction
endpackage

// File: rtl/edge_lim.sv
module edge_lim
  import edge_cov_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [VAL_W-1:0]  wr_data_i,
  input  logic              load_i,
  input  logic              step_x_i,
  input  logic              step_y_i,
  output lim_val_t          val_o
);
  localparam int A_ST = REG_BASE + 3 * IDX;

  lim_val_t st_q, dx_q, dy_q, row_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0; dx_q <= '0; dy_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(A_ST))     st_q <= wr_data_i;
      if (wr_addr_i == ADDR_W'(A_ST + 1)) dx_q <= wr_data_i;
      if (wr_addr_i == ADDR_W'(A_ST + 2)) dy_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0; cur_q <= '0;
    end else if (load_i) begin
      row_q <= st_q; cur_q <= st_q;
    end else if (step_y_i) begin
      row_q <= row_q + dy_q;
      cur_q <= row_q + dy_q;
    end else if (step_x_i) begin
      cur_q <= cur_q + dx_q;
    end
  end

  assign val_o = cur_q;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import edge_cov_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIM_W-1:0] wid_i,
  input  logic [DIM_W-1:0] hgt_i,
  output logic             load_o,
  output logic             step_x_o,
  output logic             step_y_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DIM_W-1:0] x_o,
  output logic [DIM_W-1:0] y_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;
  st_e st_q;
  logic [DIM_W-1:0] wid_q, hgt_q;
  logic last_x, last_y, empty;

  assign empty  = (wid_i == '0) || (hgt_i == '0);
  assign last_x = (x_o == wid_q - 1'b1);
  assign last_y = (y_o == hgt_q - 1'b1);
  assign load_o   = (st_q == S_IDLE) && start_i;
  assign step_x_o = (st_q == S_RUN) && !last_x;
  assign step_y_o = (st_q == S_RUN) && last_x && !last_y;
  assign busy_o   = (st_q == S_RUN);
  assign done_o   = (st_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; wid_q <= '0; hgt_q <= '0; x_o <= '0; y_o <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          wid_q <= wid_i; hgt_q <= hgt_i; x_o <= '0; y_o <= '0;
          st_q  <= empty ? S_DONE : S_RUN;
        end
        S_RUN: begin
          if (!last_x) x_o <= x_o + 1'b1;
          else begin
            x_o <= '0;
            if (last_y) st_q <= S_DONE;
            else        y_o  <= y_o + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cov_tree.sv
module cov_tree
  import edge_cov_pkg::*;
(
  input  cov_t               cov_i [NUM_LIM],
  input  logic [NUM_LIM-1:0] en_i,
  input  logic [NUM_STG-1:0] sel_i,
  output cov_t               cov_o
);
  localparam int NUM_PAIR = NUM_LIM / 2;

  function automatic cov_t mm(cov_t a, cov_t b, logic use_max);
    if (use_max) return (a > b) ? a : b;
    return (a < b) ? a : b;
  endfunction

  cov_t pair_q [NUM_PAIR];

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    cov_t lo, hi, neutral;
    assign neutral = sel_i[p] ? '0 : '1;
    assign lo = en_i[2*p]   ? cov_i[2*p]   : neutral;
    assign hi = en_i[2*p+1] ? cov_i[2*p+1] : neutral;
    assign pair_q[p] = mm(lo, hi, sel_i[p]);
  end

  cov_t stage_c;
  assign stage_c = mm(pair_q[0], pair_q[1], sel_i[3]);
  assign cov_o   = mm(stage_c, pair_q[2], sel_i[4]);
endmodule

// File: rtl/edge_cov_eval.sv
module edge_cov_eval
  import edge_cov_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [VAL_W-1:0]  wr_data_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pix_valid_o,
  output logic [DIM_W-1:0]  pix_x_o,
  output logic [DIM_W-1:0]  pix_y_o,
  output logic [COV_W-1:0]  pix_cov_o
);
  localparam int THR_LSB = NUM_LIM;
  localparam int SEL_LSB = 2 * NUM_LIM;
  localparam int HGT_LSB = 16;

  logic [NUM_LIM-1:0] en_q, thr_q;
  logic [NUM_STG-1:0] sel_q;
  logic [DIM_W-1:0]   wid_q, hgt_q;
  logic load, step_x, step_y;
  lim_val_t val [NUM_LIM];
  cov_t     cov [NUM_LIM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0; thr_q <= '0; sel_q <= '0; wid_q <= '0; hgt_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(0)) begin
        en_q  <= wr_data_i[NUM_LIM-1:0];
        thr_q <= wr_data_i[THR_LSB +: NUM_LIM];
        sel_q <= wr_data_i[SEL_LSB +: NUM_STG];
      end
      if (wr_addr_i == ADDR_W'(1)) begin
        wid_q <= wr_data_i[DIM_W-1:0];
        hgt_q <= wr_data_i[HGT_LSB +: DIM_W];
      end
    end
  end

  scan_ctrl u_scan (
    .clk_i, .rst_ni, .start_i,
    .wid_i(wid_q), .hgt_i(hgt_q),
    .load_o(load), .step_x_o(step_x), .step_y_o(step_y),
    .busy_o, .done_o, .x_o(pix_x_o), .y_o(pix_y_o)
  );

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
    edge_lim #(.IDX(i)) u_lim (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
      .load_i(load), .step_x_i(step_x), .step_y_i(step_y),
      .val_o(val[i])
    );
    assign cov[i] = clip_cov(val[i], thr_q[i]);
  end

  cov_tree u_tree (.cov_i(cov), .en_i(en_q), .sel_i(sel_q), .cov_o(pix_cov_o));

  assign pix_valid_o = busy_o;
endmodule

// File: rtl/edge_cov_chk.sv
module edge_cov_chk
  import edge_cov_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pix_valid_o,
  input logic [DIM_W-1:0] pix_x_o,
  input logic [DIM_W-1:0] pix_y_o
);
  // R9
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R9
  done_after_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  x_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(pix_valid_o) && pix_x_o != '0) |->
      (pix_x_o == DIM_W'($past(pix_x_o) + 1'b1) && pix_y_o == $past(pix_y_o)));
  // R2
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(pix_valid_o) && pix_x_o == '0) |->
      (pix_y_o == DIM_W'($past(pix_y_o) + 1'b1)));
  // R8
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> (busy_o || done_o));
  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> (busy_o || done_o));
endmodule

bind edge_cov_eval edge_cov_chk u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .pix_valid_o, .pix_x_o, .pix_y_o
);

// File: tb/sim_edge_cov_eval.sv
`timescale 1ns/1ps
module sim_edge_cov_eval;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic busy, done, pv;
  logic [10:0] px, py;
  logic [7:0] pc;

  always #5 clk = ~clk;

  edge_cov_eval u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .busy_o(busy), .done_o(done),
    .pix_valid_o(pv), .pix_x_o(px), .pix_y_o(py), .pix_cov_o(pc)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [31:0] st [6], dx [6], dy [6];
  logic [5:0] en, thr;
  logic [4:0] sel;
  int w, h;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lim_cov(int i, int x, int y);
    logic [31:0] v;
    v = st[i] + dx[i] * x + dy[i] * y;
    if (thr[i]) return v[31] ? 8'h00 : 8'hFF;
    if (v[31]) return 8'h00;
    if (v >= 32'h10000) return 8'hFF;
    return v[15:8];
  endfunction

  function automatic logic [7:0] pick(logic [7:0] a, logic [7:0] b, logic mx);
    if (mx) return (a > b) ? a : b;
    return (a < b) ? a : b;
  endfunction

  function automatic logic [7:0] exp_cov(int x, int y);
    logic [7:0] l [6];
    logic [7:0] pa, pb, pd;
    for (int i = 0; i < 6; i++)
      l[i] = en[i] ? lim_cov(i, x, y) : (sel[i/2] ? 8'h00 : 8'hFF);
    pa = pick(l[0], l[1], sel[0]);
    pb = pick(l[2], l[3], sel[1]);
    pd = pick(l[4], l[5], sel[2]);
    return pick(pick(pa, pb, sel[3]), pd, sel[4]);
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // R11: control and size field layout
  task automatic program_all();
    wr(0, {15'b0, sel, thr, en});
    wr(1, {5'b0, 11'(h), 5'b0, 11'(w)});
    for (int i = 0; i < 6; i++) begin
      wr(2 + 3*i, st[i]); wr(3 + 3*i, dx[i]); wr(4 + 3*i, dy[i]);
    end
  endtask

  task automatic run_scan(string tag, bit mid_start);
    int n = 0;
    program_all();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (w == 0 || h == 0) begin
      check("R8 valid", pv, 0);
      check("R8 busy", busy, 0);
      check("R8 done", done, 1);
      @(negedge clk);
      check("R8 done drop", done, 0);
      check("R8 no pixels", pv, 0);
      return;
    end
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        check("R2 valid", pv, 1);
        check("R9 busy", busy, 1);
        check("R2 x", px, x);
        check("R2 y", py, y);
        check(tag, pc, exp_cov(x, y));
        start = (mid_start && n == 1);
        n++;
        @(negedge clk);
        start = 0;
      end
    check("R9 done", done, 1);
    check("R9 busy low", busy, 0);
    @(negedge clk);
    check("R9 done pulse", done, 0);
    if (mid_start) begin
      repeat (3) @(negedge clk);
      check("R10 no rescan", pv, 0);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 6; i++) begin st[i] = 0; dx[i] = 0; dy[i] = 0; end
    en = 0; thr = 0; sel = 0;
  endtask

  function automatic logic [31:0] rnd_val(int span);
    return 32'($signed($urandom_range(2*span)) - span);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 valid", pv, 0);
    rst_n = 1;
    @(negedge clk);

    // graded ramp on limiter 1 alone
    clear_cfg(); en = 6'b000001;
    st[0] = 32'hFFFF_8000; dx[0] = 32'h0000_4000; dy[0] = 32'h0000_2000;
    w = 8; h = 3;
    run_scan("R3 R4 ramp", 0);

    // threshold mode
    thr = 6'b000001;
    run_scan("R5 threshold", 0);

    // all disabled: min everywhere then max pairs
    clear_cfg(); w = 3; h = 2;
    st[0] = 32'h8000;
    run_scan("R6 disabled min", 0);
    sel = 5'b00111;
    run_scan("R6 disabled max", 0);

    // two constants on pair A
    clear_cfg(); en = 6'b000011; st[0] = 32'h4000; st[1] = 32'hC000;
    w = 2; h = 2;
    run_scan("R7 min pair", 0);
    sel = 5'b00001;
    run_scan("R7 max pair", 0);

    // zero sizes
    w = 0; h = 4; run_scan("R8", 0);
    w = 5; h = 0; run_scan("R8", 0);

    // start while busy
    w = 4; h = 2; run_scan("R10 cov", 0);
    run_scan("R10 cov", 1);

    // random configurations
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 6; i++) begin
        st[i] = rnd_val(32'h20000);
        dx[i] = rnd_val(32'h8000);
        dy[i] = rnd_val(32'h8000);
      end
      en = 6'($urandom()); thr = 6'($urandom()); sel = 5'($urandom());
      w = $urandom_range(8, 1); h = $urandom_range(6, 1);
      run_scan("R7 random", 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule